// File: doc/BRIEF.md
# Two-Wire Serial Memory Write Slave

This block is the target side of a two-wire serial memory link, limited to write transactions. It oversamples the clock and data lines with the system clock and recognises START and STOP conditions. It shifts in bytes MSB first and decodes the addressing byte that opens every transaction. The block answers only when the device code, the strap-selected chip address and a write direction all match.

The byte after the addressing byte is the word address. Every later byte is handed to a page-buffer port, together with its target address. A STOP that closes a transaction holding at least one data byte raises a one-cycle commit request and starts a busy interval of fixed length. While that interval runs, the block answers nothing at all. A host can therefore poll it with addressing bytes until one is acknowledged.

Top module: `ee_wr_slave`

## Requirements
- R1: After reset, `sda_oe_o`, `busy_o`, `commit_o` and `pg_wr_o` are all low.
- R2: The addressing byte is read as bits [7:4] device code (default 4'b1010), bits [3:1] chip address and bit 0 direction (0 = write). When all three match (the chip address equal to `strap_i`) and the block is idle, it pulls SDA low for the whole ninth clock.
- R3: An addressing byte with a wrong device code or a wrong chip address gets no acknowledge. Later bytes of that transaction are not acknowledged and produce no page-buffer write.
- R4: An addressing byte with direction bit 1 gets no acknowledge.
- R5: The byte after a matching addressing byte is acknowledged and becomes the address pointer. The first data byte is written to exactly that address.
- R6: Each data byte is acknowledged. It appears on `pg_data_o` with a one-cycle `pg_wr_o` pulse, and the pointer value at that moment appears on `pg_addr_o`.
- R7: After each data byte only the low 4 pointer bits increment, wrapping inside the 16-byte page. The upper bits never change.
- R8: A STOP after at least one data byte gives a single-cycle `commit_o` pulse. `busy_o` then holds high for `WR_CYCLES` clock cycles. A STOP with no data byte commits nothing.
- R9: While `busy_o` is high, no acknowledge is driven, not even for a matching addressing byte. Once it drops, a matching addressing byte is acknowledged again.
- R10: A START in the middle of a byte abandons the transaction. The partial byte is never written, and a STOP that follows produces no commit.
- R11: SDA is only pulled low, never driven high. `sda_oe_o` rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| strap_i | input | 3 | Chip address straps |
| sda_oe_o | output | 1 | Pull SDA low when high |
| pg_wr_o | output | 1 | One-cycle page-buffer write strobe |
| pg_addr_o | output | 8 | Page-buffer write address |
| pg_data_o | output | 8 | Page-buffer write data |
| commit_o | output | 1 | One-cycle request to start the internal write |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
On every cycle, the assertions check that a commit is a single pulse always followed by busy, and that busy only starts from a commit. They also check that the acknowledge line is never driven while busy, that each page-buffer write falls inside an acknowledge slot, and that the acknowledge rises only with SCL low. The bench scenarios are needed for the behaviour that depends on what the host sends. They cover decoding of the addressing byte against device code, straps and direction, and the address each data byte lands on, including the page wrap. They also cover the length of the busy window, the polling that fails and then succeeds, and the discarding of a byte cut short by a repeated START.

// File: rtl/ee_wr_pkg.sv
package ee_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } wr_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic sda;
  } bus_evt_t;
endpackage

// File: rtl/ee_bus_cond.sv
module ee_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output ee_wr_pkg::bus_evt_t evt_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_comb begin
    evt_o.start    = scl_s && scl_q && sda_q && !sda_s;
    evt_o.stop     = scl_s && scl_q && !sda_q && sda_s;
    evt_o.scl_rise = scl_s && !scl_q;
    evt_o.scl_fall = !scl_s && scl_q;
    evt_o.sda      = sda_s;
  end
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int WR_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (kick_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ee_wr_ctrl.sv
module ee_wr_ctrl #(
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter int         ADDR_W    = 8,
  parameter int         PAGE_BITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ee_wr_pkg::bus_evt_t evt_i,
  input  logic [2:0]          strap_i,
  input  logic                busy_i,
  output logic                ack_o,
  output logic                pg_wr_o,
  output logic [ADDR_W-1:0]   pg_addr_o,
  output logic [7:0]          pg_data_o,
  output logic                commit_o
);
  import ee_wr_pkg::*;

  localparam int HI_W = ADDR_W - PAGE_BITS;

  wr_state_e         st_q;
  logic [7:0]        sr_q;
  logic [3:0]        bcnt_q;
  logic              ack_q;
  logic              have_data_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              match;
  logic              rx_active;

  assign match = (sr_q[7:4] == DEV_CODE) && (sr_q[3:1] == strap_i) &&
                 !sr_q[0] && !busy_i;
  assign rx_active = (st_q == ST_CTRL) || (st_q == ST_ADDR) || (st_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sr_q        <= '0;
      bcnt_q      <= '0;
      ack_q       <= 1'b0;
      have_data_q <= 1'b0;
      ptr_q       <= '0;
      pg_wr_o     <= 1'b0;
      pg_addr_o   <= '0;
      pg_data_o   <= '0;
      commit_o    <= 1'b0;
    end else begin
      pg_wr_o  <= 1'b0;
      commit_o <= 1'b0;
      if (evt_i.start) begin
        st_q        <= ST_CTRL;
        bcnt_q      <= '0;
        ack_q       <= 1'b0;
        have_data_q <= 1'b0;
      end else if (evt_i.stop) begin
        if (st_q == ST_DATA && have_data_q) commit_o <= 1'b1;
        st_q        <= ST_IDLE;
        bcnt_q      <= '0;
        ack_q       <= 1'b0;
        have_data_q <= 1'b0;
      end else if (rx_active) begin
        if (evt_i.scl_rise && bcnt_q < 4'd8) begin
          sr_q   <= {sr_q[6:0], evt_i.sda};
          bcnt_q <= bcnt_q + 1'b1;
        end
        if (evt_i.scl_fall) begin
          if (ack_q) begin
            // end of ninth clock
            ack_q  <= 1'b0;
            bcnt_q <= '0;
          end else if (bcnt_q == 4'd8) begin
            unique case (st_q)
              ST_CTRL: begin
                if (match) begin
                  ack_q <= 1'b1;
                  st_q  <= ST_ADDR;
                end else begin
                  st_q  <= ST_SKIP;
                end
              end
              ST_ADDR: begin
                ptr_q <= sr_q[ADDR_W-1:0];
                ack_q <= 1'b1;
                st_q  <= ST_DATA;
              end
              ST_DATA: begin
                pg_wr_o     <= 1'b1;
                pg_addr_o   <= ptr_q;
                pg_data_o   <= sr_q;
                ptr_q       <= {ptr_q[ADDR_W-1 -: HI_W], ptr_q[PAGE_BITS-1:0] + 1'b1};
                ack_q       <= 1'b1;
                have_data_q <= 1'b1;
              end
              default: st_q <= ST_SKIP;
            endcase
          end
        end
      end
    end
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/ee_wr_slave.sv
module ee_wr_slave #(
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter int         PAGE_BITS = 4,
  parameter int         WR_CYCLES = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o,
  output logic       pg_wr_o,
  output logic [7:0] pg_addr_o,
  output logic [7:0] pg_data_o,
  output logic       commit_o,
  output logic       busy_o
);
  localparam int ADDR_W = 8;

  ee_wr_pkg::bus_evt_t evt;

  ee_bus_cond #(.SYNC_STAGES(2)) u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  ee_wr_ctrl #(
    .DEV_CODE (DEV_CODE),
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .strap_i  (strap_i),
    .busy_i   (busy_o),
    .ack_o    (sda_oe_o),
    .pg_wr_o  (pg_wr_o),
    .pg_addr_o(pg_addr_o),
    .pg_data_o(pg_data_o),
    .commit_o (commit_o)
  );

  ee_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kick_i(commit_o),
    .busy_o(busy_o)
  );
endmodule

// File: rtl/ee_wr_slave_chk.sv
module ee_wr_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic pg_wr_o,
  input logic commit_o,
  input logic busy_o
);
  // R8
  commit_then_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> busy_o);

  // R8
  commit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  // R8
  busy_from_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_o));

  // R9
  no_ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  // R6
  write_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_wr_o |=> sda_oe_o);

  // R11
  ack_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
endmodule

bind ee_wr_slave ee_wr_slave_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_i   (scl_i),
  .sda_oe_o(sda_oe_o),
  .pg_wr_o (pg_wr_o),
  .commit_o(commit_o),
  .busy_o  (busy_o)
);

// File: tb/ee_wr_slave_tb.sv
module ee_wr_slave_tb;
  localparam int WR_CYCLES = 1000;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_bus;
  logic       sda_oe, pg_wr, commit, busy;
  logic [7:0] pg_addr, pg_data;

  int n_chk = 0;
  int n_err = 0;
  int commits = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  ee_wr_slave #(.WR_CYCLES(WR_CYCLES)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .strap_i  (strap),
    .sda_oe_o (sda_oe),
    .pg_wr_o  (pg_wr),
    .pg_addr_o(pg_addr),
    .pg_data_o(pg_data),
    .commit_o (commit),
    .busy_o   (busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wt(Q); sda_m = b[i]; wt(Q); scl = 1'b1; wt(2 * Q); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    wt(Q); sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    @(negedge clk); acked = sda_oe;
    wt(Q); scl = 1'b0;
  endtask

  task automatic push_exp(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pg_wr) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R10 unexpected write", {pg_addr, pg_data}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({pg_addr, pg_data} == e, "R6/R7 page write", {pg_addr, pg_data}, e);
      end
    end
    if (rst_n && commit) commits++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit a;
    int c0, cyc;
    wt(3);
    @(negedge clk);
    // R1
    chk(!sda_oe && !busy && !commit && !pg_wr, "R1 reset", {sda_oe, busy, commit, pg_wr}, 0);
    rst_n = 1'b1;
    wt(4);

    // R2 R5 R6 R8: two-byte write
    bus_start();
    send_byte(8'hAA, a); chk(a, "R2 ctrl ack", a, 1);
    send_byte(8'h35, a); chk(a, "R5 addr ack", a, 1);
    push_exp(8'h35, 8'h5C);
    send_byte(8'h5C, a); chk(a, "R6 data ack", a, 1);
    push_exp(8'h36, 8'hA3);
    send_byte(8'hA3, a); chk(a, "R6 data ack", a, 1);
    bus_stop();
    chk(commits == 1, "R8 commit", commits, 1);
    chk(busy, "R8 busy", busy, 1);

    // R9: poll while busy
    bus_start();
    send_byte(8'hAA, a); chk(!a, "R9 no ack busy", a, 0);
    bus_stop();
    while (busy) wt(1);
    bus_start();
    send_byte(8'hAA, a); chk(a, "R9 ack after busy", a, 1);
    bus_stop();
    chk(commits == 1, "R8 no data no commit", commits, 1);

    // R3: wrong straps, then wrong code
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R3 strap mismatch", a, 0);
    send_byte(8'h12, a); chk(!a, "R3 later byte", a, 0);
    send_byte(8'h34, a); chk(!a, "R3 later byte", a, 0);
    bus_stop();
    chk(commits == 1, "R3 no commit", commits, 1);
    bus_start();
    send_byte(8'h2A, a); chk(!a, "R3 code mismatch", a, 0);
    bus_stop();

    // R4
    bus_start();
    send_byte(8'hAB, a); chk(!a, "R4 read dir", a, 0);
    bus_stop();

    // R7: page wrap
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h1E, a);
    push_exp(8'h1E, 8'h11); send_byte(8'h11, a);
    push_exp(8'h1F, 8'h22); send_byte(8'h22, a);
    push_exp(8'h10, 8'h33); send_byte(8'h33, a); chk(a, "R7 wrapped ack", a, 1);
    bus_stop();
    chk(commits == 2, "R8 commit", commits, 2);
    cyc = 0;
    while (busy) begin wt(1); cyc++; end
    chk(cyc <= WR_CYCLES && cyc >= WR_CYCLES - 20, "R8 busy length", cyc, WR_CYCLES);

    // R10: start mid-byte
    c0 = commits;
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h40, a);
    push_exp(8'h40, 8'h77); send_byte(8'h77, a);
    send_bits(8'hF0, 4);
    wt(Q); sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
    bus_stop();
    wt(4);
    chk(commits == c0, "R10 abort no commit", commits, c0);
    chk(!busy, "R10 not busy", busy, 0);

    // R11
    chk(!sda_oe, "R11 released idle", sda_oe, 0);
    wt(10);
    chk(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule